// File: doc/BRIEF.md
# Oversampling UART Bit Timer

This block times the bits of a 16550-style serial port whose oversampling ratio is chosen by an extra high-speed mode register. Software writes a 16-bit divisor (through the usual line-control latch-access bit), a mode, a slot count and a sample slot over a simple byte-write port. The address is word-spaced: each 8-bit register sits at byte offset `index * 4`. From these settings the block produces two outputs. The first is a free-running transmit bit-period tick. The second is a receive sample strobe, placed inside each bit of a frame and aligned to the falling edge of the start bit.

The input clock is divided by the divisor into slots. A bit lasts a whole number of slots: 16 slots, 4 slots, or a count that software programs. The receiver is a small state machine with three states:

- `RX_IDLE` waits for a falling edge on the synchronised line. On that edge it takes the transition *start-detect* to `RX_START`, and the slot timing restarts.
- `RX_START` waits for the first sample slot. There it takes *start-confirm* to `RX_RUN` if the line is still low. If the line is high it takes *glitch-reject* back to `RX_IDLE`.
- `RX_RUN` strobes once per bit. After the final bit of the frame it takes *frame-done* back to `RX_IDLE`.

Top module: `uart_bit_timer`

## Requirements
- R1: After reset the mode is 0, the slot count is 0x00, the sample slot is 0xFF and the divisor is `RST_DIV` (default 1). The first clock after reset shows no tick, strobe or glitch, and the tick period is 16 × `RST_DIV` clocks.
- R2: Writes to index 3 (byte 0x0C) set the latch-access flag from bit 7. While the flag is 1, writes to byte 0x00 load the divisor's low byte and writes to byte 0x04 load its high byte. While the flag is 0, writes to those two addresses leave the divisor unchanged.
- R3: Mode values are written at index 0x09 (byte 0x24), and only bits 1:0 are kept. Modes 0 and 1 give 16 slots per bit with sampling at slot 8. Mode 2 gives 4 slots with sampling at slot 2. Slots are counted from 0 at the start-bit edge.
- R4: In mode 3, the slot count (index 0x0A, byte 0x28) and the sample slot (index 0x0B, byte 0x2C) take effect when the count is nonzero and the sample slot does not exceed it. A bit then has count+1 slots, and sampling happens in the sample slot.
- R5: In mode 3 with a zero slot count, or with a sample slot above the count, the block falls back to 16 slots with sampling at slot 8.
- R6: A divisor of 0 behaves exactly like a divisor of 1.
- R7: `tx_tick` is a one-clock pulse that repeats every slots × divisor clocks.
- R8: Call the first rising edge at which `rx_in` is low, after being high while idle, edge 1. The first `rx_strobe` is high after edge sample_slot × divisor + 4. At that strobe `rx_bit` is 0.
- R9: After a confirmed start, `FRAME_BITS` strobes are issued in total (default 10), spaced slots × divisor clocks apart. Each strobe carries the synchronised line level on `rx_bit`. No strobe follows the last one until a new start edge arrives.
- R10: If the line is high at the first sample slot, the block pulses `rx_glitch` with `rx_bit` = 1, gives no strobe and returns to idle.
- R11: Falling edges on the line during a frame do not restart the slot timing.
- R12: Writes to index 0x0D (byte 0x34) are ignored. So are writes to other unmapped indices and writes whose address bits 1:0 are not 0. None of them changes the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Byte address (word-spaced registers) |
| wdata | input | 8 | Write data |
| rx_in | input | 1 | Asynchronous serial receive line |
| tx_tick | output | 1 | Transmit bit-period pulse |
| rx_strobe | output | 1 | Receive sample strobe |
| rx_bit | output | 1 | Line level taken at the last sample slot |
| rx_glitch | output | 1 | Start bit rejected at its first sample |

## Verification
The assertions assume that every bit period is at least two clocks long; the slot table guarantees this because it never selects fewer than 2 slots. They also assume that reset is held from time zero. The bench never changes the configuration in the middle of a frame. It changes `rx_in` only on the falling clock edge right after a strobe, which keeps each level change well clear of the next sample slot for all the configurations it sweeps. It always lets the tick realign once before it measures a period.

// File: rtl/uart_bt_pkg.sv
package uart_bt_pkg;
    typedef enum logic [1:0] {
        HS_X16  = 2'd0,
        HS_RSVD = 2'd1,
        HS_X4   = 2'd2,
        HS_PROG = 2'd3
    } hs_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_RUN   = 2'd2
    } rx_state_e;

    localparam int IX_DLO   = 0;
    localparam int IX_DHI   = 1;
    localparam int IX_LCTL  = 3;
    localparam int IX_MODE  = 9;
    localparam int IX_SCNT  = 10;
    localparam int IX_SPNT  = 11;
    localparam int SLOT_W   = 8;
endpackage

// File: rtl/bt_regs.sv
module bt_regs
    import uart_bt_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int ADDR_W  = 6,
    parameter int RST_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [DIV_W-1:0]  div_o,
    output hs_mode_e          mode_o,
    output logic [SLOT_W-1:0] scnt_o,
    output logic [SLOT_W-1:0] spnt_o
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             latch_q;

    assign idx     = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
            div_o   <= DIV_W'(RST_DIV);
            mode_o  <= HS_X16;
            scnt_o  <= 8'h00;
            spnt_o  <= 8'hFF;
        end else if (wr_en && aligned) begin
            if (idx == IDX_W'(IX_LCTL)) latch_q <= wdata[7];
            if (latch_q && idx == IDX_W'(IX_DLO)) div_o[7:0] <= wdata;
            if (latch_q && idx == IDX_W'(IX_DHI)) div_o[DIV_W-1:8] <= wdata[DIV_W-9:0];
            if (idx == IDX_W'(IX_MODE)) mode_o <= hs_mode_e'(wdata[1:0]);
            if (idx == IDX_W'(IX_SCNT)) scnt_o <= wdata;
            if (idx == IDX_W'(IX_SPNT)) spnt_o <= wdata;
        end
    end
endmodule

// File: rtl/bt_slot_cfg.sv
module bt_slot_cfg
    import uart_bt_pkg::*;
(
    input  hs_mode_e          mode,
    input  logic [SLOT_W-1:0] scnt,
    input  logic [SLOT_W-1:0] spnt,
    output logic [SLOT_W-1:0] last_slot,
    output logic [SLOT_W-1:0] samp_slot
);
    always_comb begin
        unique case (mode)
            HS_X4: begin
                last_slot = 8'd3;
                samp_slot = 8'd2;
            end
            HS_PROG: begin
                if (scnt != 8'd0 && spnt <= scnt) begin
                    last_slot = scnt;
                    samp_slot = spnt;
                end else begin
                    last_slot = 8'd15;
                    samp_slot = 8'd8;
                end
            end
            default: begin
                last_slot = 8'd15;
                samp_slot = 8'd8;
            end
        endcase
    end
endmodule

// File: rtl/bt_tx_timer.sv
module bt_tx_timer
    import uart_bt_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  eff_div,
    input  logic [SLOT_W-1:0] last_slot,
    output logic              tick
);
    logic [DIV_W-1:0]  pcnt_q;
    logic [SLOT_W-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            slot_q <= '0;
            tick   <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (pcnt_q >= eff_div - DIV_W'(1)) begin
                pcnt_q <= '0;
                if (slot_q >= last_slot) begin
                    slot_q <= '0;
                    tick   <= 1'b1;
                end else begin
                    slot_q <= slot_q + SLOT_W'(1);
                end
            end else begin
                pcnt_q <= pcnt_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/bt_rx_fsm.sv
module bt_rx_fsm
    import uart_bt_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int FRAME_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [DIV_W-1:0]  eff_div,
    input  logic [SLOT_W-1:0] last_slot,
    input  logic [SLOT_W-1:0] samp_slot,
    output logic              strobe,
    output logic              bit_val,
    output logic              glitch
);
    localparam int BIT_W = $clog2(FRAME_BITS + 1);

    rx_state_e         state_q, state_d;
    logic              s1_q, s2_q, s3_q;
    logic [DIV_W-1:0]  pcnt_q;
    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bitn_q;
    logic              fall, at_samp, bit_last;

    assign fall     = s3_q & ~s2_q;
    assign at_samp  = (state_q != RX_IDLE) && (pcnt_q == '0) && (slot_q == samp_slot);
    assign bit_last = (bitn_q == BIT_W'(FRAME_BITS - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall) state_d = RX_START;
            RX_START: if (at_samp) state_d = (s2_q || FRAME_BITS == 1) ? RX_IDLE : RX_RUN;
            RX_RUN:   if (at_samp && bit_last) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            s3_q   <= 1'b1;
            pcnt_q <= '0;
            slot_q <= '0;
            bitn_q <= '0;
        end else begin
            s1_q <= rx_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
            if (state_q == RX_IDLE) begin
                pcnt_q <= '0;
                slot_q <= '0;
                bitn_q <= '0;
            end else begin
                if (at_samp) bitn_q <= bitn_q + BIT_W'(1);
                if (pcnt_q >= eff_div - DIV_W'(1)) begin
                    pcnt_q <= '0;
                    slot_q <= (slot_q >= last_slot) ? '0 : slot_q + SLOT_W'(1);
                end else begin
                    pcnt_q <= pcnt_q + DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe  <= 1'b0;
            glitch  <= 1'b0;
            bit_val <= 1'b1;
        end else begin
            strobe <= at_samp && (state_q == RX_RUN || (state_q == RX_START && !s2_q));
            glitch <= at_samp && (state_q == RX_START) && s2_q;
            if (at_samp) bit_val <= s2_q;
        end
    end
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer
    import uart_bt_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int ADDR_W     = 6,
    parameter int FRAME_BITS = 10,
    parameter int RST_DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              rx_in,
    output logic              tx_tick,
    output logic              rx_strobe,
    output logic              rx_bit,
    output logic              rx_glitch
);
    logic [DIV_W-1:0]  div_raw, eff_div;
    hs_mode_e          mode;
    logic [SLOT_W-1:0] scnt, spnt, last_slot, samp_slot;

    assign eff_div = (div_raw == '0) ? DIV_W'(1) : div_raw;

    bt_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .RST_DIV(RST_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .div_o(div_raw), .mode_o(mode), .scnt_o(scnt), .spnt_o(spnt)
    );

    bt_slot_cfg u_cfg (
        .mode(mode), .scnt(scnt), .spnt(spnt),
        .last_slot(last_slot), .samp_slot(samp_slot)
    );

    bt_tx_timer #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .eff_div(eff_div),
        .last_slot(last_slot), .tick(tx_tick)
    );

    bt_rx_fsm #(.DIV_W(DIV_W), .FRAME_BITS(FRAME_BITS)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .eff_div(eff_div),
        .last_slot(last_slot), .samp_slot(samp_slot),
        .strobe(rx_strobe), .bit_val(rx_bit), .glitch(rx_glitch)
    );
endmodule

// File: rtl/uart_bit_timer_chk.sv
module uart_bit_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_tick,
    input logic rx_strobe,
    input logic rx_bit,
    input logic rx_glitch
);
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!tx_tick && !rx_strobe && !rx_glitch));

    p_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |=> !tx_tick);

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    p_glitch_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_glitch |-> (!rx_strobe && rx_bit));
endmodule

bind uart_bit_timer uart_bit_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_tick(tx_tick),
    .rx_strobe(rx_strobe), .rx_bit(rx_bit), .rx_glitch(rx_glitch)
);

// File: tb/test_uart_bit_timer.sv
module test_uart_bit_timer;
    localparam int FB = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       rx_in = 1'b1;
    logic       tx_tick, rx_strobe, rx_bit, rx_glitch;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    uart_bit_timer #(.FRAME_BITS(FB)) i_uart_bit_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rx_in(rx_in), .tx_tick(tx_tick), .rx_strobe(rx_strobe),
        .rx_bit(rx_bit), .rx_glitch(rx_glitch)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles, expected under 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_div(input int d);
        wr(6'h0C, 8'h80);
        wr(6'h00, d[7:0]);
        wr(6'h04, d[15:8]);
        wr(6'h0C, 8'h03);
    endtask

    // clocks between two successive ticks, after one tick to realign
    task automatic tick_period(output int p);
        int n;
        n = 0;
        while (!tx_tick && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
        p = 0;
        do begin @(posedge clk); @(negedge clk); p++; end while (!tx_tick && p < 5000);
    endtask

    task automatic count_to_strobe(output int n);
        n = 0;
        do begin @(posedge clk); @(negedge clk); n++; end while (!rx_strobe && !rx_glitch && n < 5000);
    endtask

    task automatic rx_frame(input int samp, input int slots, input int div, input string tag);
        int n;
        logic v;
        @(negedge clk);
        rx_in = 1'b0;
        count_to_strobe(n);
        chk({tag, " R8 first strobe latency"}, n, samp * div + 4);
        chk({tag, " R8 start bit level"}, int'(rx_bit), 0);
        for (int b = 1; b < FB; b++) begin
            v = (b == FB - 1) ? 1'b1 : logic'(b % 2);
            rx_in = v;
            count_to_strobe(n);
            chk({tag, " R9 R11 strobe spacing"}, n, slots * div);
            chk({tag, " R9 sampled level"}, int'(rx_bit), int'(v));
        end
        n = 0;
        for (int k = 0; k < 2 * slots * div; k++) begin
            @(posedge clk); @(negedge clk);
            if (rx_strobe) n++;
        end
        chk({tag, " R9 no strobe after frame"}, n, 0);
    endtask

    initial begin
        int p, n, g;
        int modes[7] = '{0, 1, 2, 3, 3, 3, 3};
        int scs[7]   = '{0, 0, 0, 5, 0, 5, 3};
        int sps[7]   = '{255, 255, 255, 2, 255, 9, 1};
        int exs[7]   = '{16, 16, 4, 6, 16, 16, 4};
        int exp_s[7] = '{8, 8, 2, 2, 8, 8, 1};
        int divs[4]  = '{0, 1, 2, 3};

        repeat (3) @(negedge clk);
        chk("R1 reset tick low", int'(tx_tick), 0);
        chk("R1 reset strobe low", int'(rx_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 no pulse after reset", int'(tx_tick | rx_strobe | rx_glitch), 0);
        tick_period(p);
        chk("R1 default period", p, 16);

        for (int c = 0; c < 7; c++) begin
            wr(6'h24, 8'(modes[c]));
            wr(6'h28, 8'(scs[c]));
            wr(6'h2C, 8'(sps[c]));
            for (int d = 0; d < 4; d++) begin
                int ed;
                ed = (divs[d] == 0) ? 1 : divs[d];
                set_div(divs[d]);
                tick_period(p);
                chk("R3 R4 R5 R6 R7 tick period", p, exs[c] * ed);
                rx_frame(exp_s[c], exs[c], ed, "R3 R4 R5 R6");
            end
        end

        // R2: high byte and latch gating, mode 2
        wr(6'h24, 8'h02);
        set_div(257);
        tick_period(p);
        chk("R2 high byte divisor", p, 4 * 257);
        set_div(2);
        wr(6'h00, 8'h07);
        wr(6'h04, 8'h01);
        tick_period(p);
        chk("R2 writes without latch flag ignored", p, 8);

        // R12: ignored addresses
        wr(6'h34, 8'h00);
        wr(6'h34, 8'h5A);
        wr(6'h38, 8'hFF);
        wr(6'h25, 8'h00);
        wr(6'h29, 8'h07);
        tick_period(p);
        chk("R12 ignored writes keep period", p, 8);

        // R10: glitch rejected, mode 0, divisor 2
        wr(6'h24, 8'h00);
        @(negedge clk);
        rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rx_in = 1'b1;
        n = 3;
        while (!rx_glitch && !rx_strobe && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
        chk("R10 glitch flagged at sample slot", n, 8 * 2 + 4);
        chk("R10 no strobe with glitch", int'(rx_strobe), 0);
        g = 0;
        for (int k = 0; k < 64; k++) begin
            @(posedge clk); @(negedge clk);
            if (rx_strobe) g++;
        end
        chk("R10 back to idle without strobes", g, 0);
        rx_frame(8, 16, 2, "R10 after glitch");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule